// File: doc/BRIEF.md
# Two-Operand Integer Execute Unit

This block is the execute stage of a 64-bit integer core that uses a destructive two-address form. The destination register is also the first operand. Each instruction arrives already decoded: an opcode, a destination index, and a second operand. The second operand is either a register or a 32-bit immediate that is sign-extended to 64 bits. The unit reads its own sixteen-entry register file, computes the result and writes it back. Each write is reported on a registered writeback port.

Most operations finish on the clock edge that accepts them. These are copy, the three bitwise operations, wrapping add, subtract and multiply, and increment/decrement. Unsigned division runs on a one-bit-per-cycle divider and stalls the input handshake while it works. Division by zero completes at once with an all-ones result and a flag. Register 0 reads as zero and silently drops writes. Any destination code that names the program counter (codes 16 to 31) is refused and flagged. The program counter itself lives outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is high exactly when `busy` is low. For every non-divide operation, the register write happens on that accepting edge. The result appears on `wb_valid`/`wb_idx`/`wb_data` for the one cycle that follows.
- R2: Register 0 always reads as zero. A write aimed at destination 0 changes nothing and leaves `wb_valid` low.
- R3: Registers 1 to 15 keep the last value written to them, and a later instruction that reads them sees that value.
- R4: Opcode 0 copies the second operand into the destination. Opcodes 1, 2 and 3 store destination AND, OR and XOR the second operand.
- R5: Opcodes 4, 5 and 6 store destination plus, minus and times the second operand, all modulo 2^64. For the product only the low 64 bits are kept.
- R6: Opcode 8 adds one to the destination and opcode 9 subtracts one, both wrapping. The second operand fields have no effect on either.
- R7: With `in_src_imm` = 1 the second operand is `in_imm` sign-extended from bit 31. With `in_src_imm` = 0 it is the register named by `in_src_reg`.
- R8: A destination code of 16 or more is the program counter. It is never written, `wb_valid` stays low, and `err_illegal_dst` pulses for one cycle after the accepting edge. No other flag is raised and no division starts.
- R9: Opcode 7 performs unsigned division destination / operand with a nonzero divisor. `busy` is high for the 64 cycles after the accepting edge and `in_ready` is low during that time. On the 64th edge after acceptance the quotient is written, and `done` and the writeback pulse together.
- R10: Opcode 7 with a zero divisor writes all ones to the destination on the accepting edge. For the following cycle it pulses `err_div_zero` and `done` together, and `busy` never rises.
- R11: Opcodes 10 to 15 are accepted and write nothing: no writeback, no flag and no register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_op | input | 4 | Decoded opcode |
| in_dst | input | 5 | Destination index; 0-15 integer registers, 16-31 program counter |
| in_src_imm | input | 1 | 1 selects the immediate as second operand |
| in_src_reg | input | 4 | Second-operand register index |
| in_imm | input | 32 | Immediate, sign-extended to 64 bits |
| busy | output | 1 | Divider occupied |
| wb_valid | output | 1 | A register was written on the previous edge |
| wb_idx | output | 4 | Register that was written |
| wb_data | output | 64 | Value that was written |
| done | output | 1 | A division completed on the previous edge |
| err_illegal_dst | output | 1 | Previous accepted instruction targeted the program counter |
| err_div_zero | output | 1 | Previous accepted instruction divided by zero |

## Verification
A corrupted register file entry stays hidden until an instruction reads it. It then shows as a wrong `wb_data` on the cycle right after that read. The bench therefore reuses registers as sources and destinations throughout, so a bad entry surfaces within a few instructions. A divider whose step counter or partial remainder goes wrong shows up in two ways: `busy` falls on the wrong edge, which the bench sees on the very cycle it happens, or the quotient is wrong when `done` pulses 64 cycles after acceptance. A wrongly decoded destination class shows up on the next cycle. It appears as a writeback where a flag was due, or a flag where a writeback was due.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0,
    OP_AND = 4'd1,
    OP_OR  = 4'd2,
    OP_XOR = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_MUL = 4'd6,
    OP_DIV = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } exu_op_e;

endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr [NRD],
  output logic [XLEN-1:0] rdata [NRD]
);

  logic [XLEN-1:0] mem [NREGS];

  // Entry 0 is never written; the read mux supplies zero for it.
  always_ff @(posedge clk) begin
    if (we && waddr != AW'(0)) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == AW'(0)) ? '0 : mem[raddr[g]];
  end

  // R3: a write to a general register lands and is readable one edge later
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != AW'(0)) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            known
);

  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  always_comb begin
    known = 1'b1;
    case (op)
      OP_MOV:  res = b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_INC:  res = a + ONE;
      OP_DEC:  res = a - ONE;
      default: begin
        res   = a;
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/exu_divider.sv
module exu_divider #(
  parameter int XLEN = 64,
  parameter int TAGW = 4,
  localparam int CW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic [TAGW-1:0] tag_in,
  output logic            busy,
  output logic            fin,
  output logic [XLEN-1:0] quotient,
  output logic [TAGW-1:0] tag_out
);

  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   rem_sh, rem_nx;
  logic            take;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    rem_sh   = {rem_q, quo_q[XLEN-1]};
    take     = (rem_sh >= {1'b0, dvs_q});
    rem_nx   = take ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
    quotient = {quo_q[XLEN-2:0], take};
  end

  assign fin     = busy && (cnt_q == CW'(XLEN - 1));
  assign tag_out = tag_q;

  logic [TAGW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
      tag_q <= tag_in;
    end else if (busy) begin
      rem_q <= rem_nx[XLEN-1:0];
      quo_q <= quotient;
      cnt_q <= cnt_q + CW'(1);
      if (fin) busy <= 1'b0;
    end
  end

  // R9: a running division stays busy until its last step
  a_r9_busy_until_last: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> busy);

  // R9: a new division is only launched on an idle divider
  a_r9_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 16,
  parameter int IMM_W = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int DW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [DW-1:0]   in_dst,
  input  logic            in_src_imm,
  input  logic [AW-1:0]   in_src_reg,
  input  logic [IMM_W-1:0] in_imm,
  output logic            busy,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            done,
  output logic            err_illegal_dst,
  output logic            err_div_zero
);

  logic            fire, dst_is_pc, is_div, div_zero, alu_known, div_start;
  logic [AW-1:0]   dst_ix;
  logic [XLEN-1:0] dst_val, src_val, imm_ext, alu_res;
  logic [AW-1:0]   rf_raddr [2];
  logic [XLEN-1:0] rf_rdata [2];
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic            div_busy, div_fin;
  logic [XLEN-1:0] div_q;
  logic [AW-1:0]   div_tag;

  assign in_ready  = !div_busy;
  assign busy      = div_busy;
  assign fire      = in_valid && in_ready;
  assign dst_is_pc = in_dst[AW];
  assign dst_ix    = in_dst[AW-1:0];
  assign is_div    = (in_op == OP_DIV);
  assign imm_ext   = {{(XLEN-IMM_W){in_imm[IMM_W-1]}}, in_imm};

  assign rf_raddr[0] = dst_ix;
  assign rf_raddr[1] = in_src_reg;
  assign dst_val     = rf_rdata[0];
  assign src_val     = in_src_imm ? imm_ext : rf_rdata[1];
  assign div_zero    = is_div && (src_val == '0);
  assign div_start   = fire && !dst_is_pc && is_div && !div_zero;

  exu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  exu_alu #(.XLEN(XLEN)) u_alu (
    .op    (in_op),
    .a     (dst_val),
    .b     (src_val),
    .res   (alu_res),
    .known (alu_known)
  );

  exu_divider #(.XLEN(XLEN), .TAGW(AW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (dst_val),
    .divisor  (src_val),
    .tag_in   (dst_ix),
    .busy     (div_busy),
    .fin      (div_fin),
    .quotient (div_q),
    .tag_out  (div_tag)
  );

  // Single write port: divider completion and accepted instructions never
  // coincide because acceptance requires an idle divider.
  always_comb begin
    if (div_fin) begin
      rf_we    = 1'b1;
      rf_waddr = div_tag;
      rf_wdata = div_q;
    end else begin
      rf_we    = fire && !dst_is_pc && (is_div ? div_zero : alu_known);
      rf_waddr = dst_ix;
      rf_wdata = is_div ? '1 : alu_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid        <= 1'b0;
      wb_idx          <= '0;
      wb_data         <= '0;
      done            <= 1'b0;
      err_illegal_dst <= 1'b0;
      err_div_zero    <= 1'b0;
    end else begin
      wb_valid        <= rf_we && (rf_waddr != AW'(0));
      wb_idx          <= rf_waddr;
      wb_data         <= rf_wdata;
      done            <= div_fin || (fire && !dst_is_pc && div_zero);
      err_illegal_dst <= fire && dst_is_pc;
      err_div_zero    <= fire && !dst_is_pc && div_zero;
    end
  end

  // R2: register 0 is never reported as written
  a_r2_no_zero_wb: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != AW'(0)));

  // R8: a refused program-counter target produces no write and no completion
  a_r8_pc_blocked: assert property (@(posedge clk) disable iff (rst)
    err_illegal_dst |-> (!wb_valid && !done && !err_div_zero));

  // R9: the divider going idle coincides with the completion pulse
  a_r9_done_on_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R10: a zero divisor completes without occupying the divider
  a_r10_dz_no_stall: assert property (@(posedge clk) disable iff (rst)
    err_div_zero |-> (done && !busy));

  // R1: an accepted copy to a general register is reported on the next cycle
  a_r1_copy_writes_next: assert property (@(posedge clk) disable iff (rst)
    (fire && !dst_is_pc && in_op == OP_MOV && dst_ix != AW'(0))
      |=> (wb_valid && wb_idx == $past(dst_ix)));

endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_op;
  logic [4:0]  in_dst;
  logic        in_src_imm;
  logic [3:0]  in_src_reg;
  logic [31:0] in_imm;
  logic        busy, wb_valid, done, err_illegal_dst, err_div_zero;
  logic [3:0]  wb_idx;
  logic [63:0] wb_data;

  always #10 clk = ~clk;

  int_exec_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_imm(in_src_imm),
    .in_src_reg(in_src_reg), .in_imm(in_imm), .busy(busy),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done),
    .err_illegal_dst(err_illegal_dst), .err_div_zero(err_div_zero)
  );

  // Reference model state
  logic [63:0] m_reg [16];
  bit          m_busy, m_acc;
  int          m_cnt;
  logic [63:0] m_dres;
  logic [3:0]  m_ddst;
  string       m_dreq, in_req, e_req;
  bit          e_wbv, e_done, e_ill, e_dz;
  logic [3:0]  e_idx;
  logic [63:0] e_data;
  bit          cmp_en = 0, ended = 0;
  int          checks = 0, failures = 0;

  function automatic logic [63:0] ref_op(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    case (op)
      4'd0: return b;
      4'd1: return a & b;
      4'd2: return a | b;
      4'd3: return a ^ b;
      4'd4: return a + b;
      4'd5: return a - b;
      4'd6: return a * b;
      4'd8: return a + 64'd1;
      default: return a - 64'd1;
    endcase
  endfunction

  function void mwrite(logic [3:0] idx, logic [63:0] v);
    if (idx != 4'd0) begin
      m_reg[idx] = v;
      e_wbv  = 1;
      e_idx  = idx;
      e_data = v;
    end
  endfunction

  initial for (int i = 0; i < 16; i++) m_reg[i] = 64'd0;

  always @(posedge clk) begin : model
    logic [63:0] a, b;
    m_acc = 0;
    e_wbv = 0; e_done = 0; e_ill = 0; e_dz = 0;
    if (rst) begin
      m_busy = 0;
      m_cnt  = 0;
      e_req  = "R1";
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0;
        e_done = 1;
        e_req  = m_dreq;
        mwrite(m_ddst, m_dres);
      end
    end else if (in_valid) begin
      m_acc = 1;
      e_req = in_req;
      a = (in_dst[3:0] == 4'd0) ? 64'd0 : m_reg[in_dst[3:0]];
      b = in_src_imm ? {{32{in_imm[31]}}, in_imm}
                     : ((in_src_reg == 4'd0) ? 64'd0 : m_reg[in_src_reg]);
      if (in_dst >= 5'd16) e_ill = 1;
      else if (in_op == 4'd7) begin
        if (b == 64'd0) begin
          e_dz = 1; e_done = 1;
          mwrite(in_dst[3:0], '1);
        end else begin
          m_busy = 1; m_cnt = 64;
          m_dres = a / b; m_ddst = in_dst[3:0]; m_dreq = in_req;
        end
      end else if (in_op <= 4'd9) mwrite(in_dst[3:0], ref_op(in_op, a, b));
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", e_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en && !ended) begin
    chk("busy", 64'(busy), 64'(m_busy));
    chk("in_ready", 64'(in_ready), 64'(!m_busy));
    chk("wb_valid", 64'(wb_valid), 64'(e_wbv));
    chk("done", 64'(done), 64'(e_done));
    chk("err_illegal_dst", 64'(err_illegal_dst), 64'(e_ill));
    chk("err_div_zero", 64'(err_div_zero), 64'(e_dz));
    if (e_wbv) begin
      chk("wb_idx", 64'(wb_idx), 64'(e_idx));
      chk("wb_data", wb_data, e_data);
    end
  end

  task automatic issue(string req, logic [3:0] op, logic [4:0] dst,
                       bit isimm, logic [3:0] src, logic [31:0] imm);
    in_req = req; in_op = op; in_dst = dst; in_src_imm = isimm;
    in_src_reg = src; in_imm = imm; in_valid = 1;
    do @(negedge clk); while (!m_acc);
  endtask

  task automatic idle(int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    rst = 1; in_valid = 0; in_op = 0; in_dst = 0; in_src_imm = 0;
    in_src_reg = 0; in_imm = 0; in_req = "R1";
    @(posedge clk);
    cmp_en = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    // R1 / R3: fill every general register back to back
    for (int i = 1; i < 16; i++) issue("R3", 4'd0, 5'(i), 1, 4'd0, 32'(i) * 32'h0101_0013);
    idle(1);
    // R7: sign extension of a negative immediate, positive immediate, register source
    issue("R7", 4'd0, 5'd1, 1, 4'd0, 32'h8000_0001);
    issue("R7", 4'd0, 5'd2, 1, 4'd0, 32'h7fff_fff0);
    issue("R7", 4'd0, 5'd3, 0, 4'd1, 32'hdead_beef);
    // R4: copy and bitwise forms
    issue("R4", 4'd0, 5'd4, 0, 4'd13, 32'd0);
    issue("R4", 4'd1, 5'd3, 1, 4'd0, 32'hffff_ff0f);
    issue("R4", 4'd2, 5'd4, 0, 4'd1, 32'd0);
    issue("R4", 4'd3, 5'd5, 1, 4'd0, 32'hffff_ffff);
    issue("R4", 4'd3, 5'd6, 0, 4'd6, 32'd0);
    // R5: wrapping arithmetic
    issue("R5", 4'd0, 5'd6, 1, 4'd0, 32'hffff_ffff);
    issue("R5", 4'd4, 5'd6, 1, 4'd0, 32'd1);
    issue("R5", 4'd5, 5'd6, 1, 4'd0, 32'd1);
    issue("R5", 4'd0, 5'd7, 1, 4'd0, 32'h7fff_ffff);
    issue("R5", 4'd6, 5'd7, 0, 4'd7, 32'd0);
    issue("R5", 4'd6, 5'd7, 0, 4'd6, 32'd0);
    issue("R5", 4'd4, 5'd9, 0, 4'd15, 32'd0);
    // R6: increment / decrement ignore the operand fields
    issue("R6", 4'd8, 5'd6, 1, 4'd0, 32'h1234_5678);
    issue("R6", 4'd8, 5'd6, 0, 4'd15, 32'd0);
    issue("R6", 4'd9, 5'd6, 1, 4'd0, 32'hffff_ffff);
    issue("R6", 4'd9, 5'd6, 0, 4'd2, 32'd7);
    issue("R6", 4'd9, 5'd6, 0, 4'd2, 32'd7);
    // R2: register 0 reads zero, writes dropped
    issue("R2", 4'd0, 5'd0, 1, 4'd0, 32'd5);
    issue("R2", 4'd4, 5'd0, 1, 4'd0, 32'd1);
    issue("R2", 4'd0, 5'd8, 0, 4'd0, 32'd9);
    issue("R2", 4'd2, 5'd9, 0, 4'd0, 32'd0);
    // R8: program counter destinations refused
    issue("R8", 4'd0, 5'd16, 1, 4'd0, 32'd3);
    issue("R8", 4'd4, 5'd23, 0, 4'd1, 32'd0);
    issue("R8", 4'd0, 5'd10, 0, 4'd1, 32'd0);
    // R11: undefined opcodes do nothing
    issue("R11", 4'd12, 5'd11, 1, 4'd0, 32'd77);
    issue("R11", 4'd15, 5'd11, 0, 4'd1, 32'd0);
    issue("R11", 4'd0, 5'd12, 0, 4'd11, 32'd0);
    // R9: multi-cycle division, next instruction held during busy
    issue("R9", 4'd0, 5'd8, 1, 4'd0, 32'd100);
    issue("R9", 4'd7, 5'd8, 1, 4'd0, 32'd7);
    issue("R9", 4'd4, 5'd8, 1, 4'd0, 32'd1);
    issue("R9", 4'd0, 5'd9, 1, 4'd0, 32'd3);
    issue("R9", 4'd7, 5'd6, 0, 4'd9, 32'd0);
    issue("R9", 4'd7, 5'd5, 1, 4'd0, 32'd1);
    issue("R9", 4'd7, 5'd9, 0, 4'd6, 32'd0);
    issue("R9", 4'd7, 5'd0, 1, 4'd0, 32'd2);
    issue("R9", 4'd0, 5'd13, 0, 4'd9, 32'd0);
    // R10: zero divisor
    issue("R10", 4'd7, 5'd10, 1, 4'd0, 32'd0);
    issue("R10", 4'd7, 5'd11, 0, 4'd0, 32'd0);
    issue("R10", 4'd7, 5'd0, 1, 4'd0, 32'd0);
    issue("R10", 4'd4, 5'd10, 1, 4'd0, 32'd2);
    // R8: division aimed at the program counter starts nothing
    issue("R8", 4'd7, 5'd16, 1, 4'd0, 32'd0);
    issue("R8", 4'd7, 5'd17, 1, 4'd0, 32'd5);
    issue("R8", 4'd0, 5'd14, 0, 4'd10, 32'd0);
    idle(4);
    finish_run();
  end

endmodule